// File: doc/BRIEF.md
# Data Translation Fault Classifier

This block sits on the data side of a memory pipeline and turns one load or store request into a physical address, a fault code and a memory-management status word. It takes the virtual address, the access size, the direction, and request qualifiers: physical bypass, use-alternate-mode, page-table walk. It also takes the low bit of the program counter, the current and alternate privilege modes and the address-space number. It runs the checks in a fixed order: alignment, then address form, then the kernel-only direct-mapped window, then the translation lookup with its permission and fault-on bits, and last the physical-address range and uncacheable rules.

The translation entries live in a separate lookaside buffer. This block presents the virtual page number and address-space number on combinational outputs and reads back the hit flag, the page number, the per-mode enable masks and the fault-on flags in the same cycle. It registers the result one cycle after the request. Eight event counters keep separate read and write tallies of table accesses, hits, misses and violations, and four total outputs give their sums.

Top module: `dtx_fault_classifier`

## Requirements
- R1: Alignment is checked before anything else. If an address bit below the access size is set, the fault code is 1 (alignment) and the status holds only the write bit (bit 0) for a store, whatever the other inputs are.
- R2: The effective mode equals the current mode when the PC low bit is 0. When the PC low bit is 1, it is the alternate mode if the alternate flag is set, and kernel (0) if it is not. Modes are 0 kernel, 1 executive, 2 supervisor, 3 user, and an enable mask bit n grants mode n.
- R3: In a non-bypass request, an address whose bits 63:47 are not all equal gives fault code 3 (page fault). The status is bad-address (bit 5) plus access-violation (bit 1), plus write (bit 0) for a store.
- R4: A non-bypass address whose bits 47:41 equal 0x7E is direct-mapped only when the current mode (not the effective mode) is kernel. The physical address is then the low 44 bits, with bits 43:40 forced to 1 if bit 40 is set, or bits 43:40 cleared otherwise. In any other mode the fault code is 2 (access violation), with status access-violation plus write for a store.
- R5: A lookup miss gives fault code 4 when the page-table flag is set and 5 when it is clear. The status is miss (bit 4) plus write for a store. The lookup outputs carry virtual bits 47:13 and the address-space number.
- R6: On a store hit where the write-enable bit of the effective mode is clear, the fault code is 3 and the status is write plus access-violation, plus fault-on-write (bit 3) if the entry sets it. If the enable bit is set but fault-on-write is set, the code is 3 and the status is write plus fault-on-write.
- R7: On a load hit where the read-enable bit of the effective mode is clear, the fault code is 2 and the status is access-violation, plus fault-on-read (bit 2) if the entry sets it. If the enable bit is set but fault-on-read is set, the code is 3 and the status is fault-on-read alone.
- R8: On a permitted hit the physical address is the page number shifted left by 13 plus virtual bits 12:0. A bypass request uses the virtual address unchanged. For a hit, bypass or direct-mapped result with any bit at or above bit 44 set, the fault code is 6 (machine check) and the status is 0.
- R9: A fault-free result with physical bit 43 set raises the uncacheable output and clears physical bits 42:35. Every other result leaves the uncacheable output low.
- R10: The table-access counters count non-bypass requests outside the direct-mapped window. Hit counters count permitted hits, bypass and direct-mapped results. Violation counters count bad-address, window-mode and permission or fault-on faults. Alignment faults count nowhere. Each total equals the read count plus the write count.
- R11: Any size code other than 1, 2, 4 or 8 is handled as a 1-byte access and never raises an alignment fault.
- R12: The response valid output follows the request valid input by exactly one cycle. The fault code is 0 for a clean result, and the status is 0 whenever the fault code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 64 | Virtual address |
| req_size | input | 4 | Access size in bytes |
| req_write | input | 1 | 1 for a store |
| req_phys | input | 1 | Physical bypass |
| req_alt | input | 1 | Use alternate mode (when PC low bit set) |
| req_ptacc | input | 1 | Request is a page-table walk |
| pc_lsb | input | 1 | Low bit of the program counter |
| cur_mode | input | 2 | Current privilege mode |
| alt_mode | input | 2 | Alternate privilege mode |
| req_asn | input | 8 | Address-space number |
| tlb_vpn | output | 35 | Lookup virtual page number |
| tlb_asn | output | 8 | Lookup address-space number |
| tlb_hit | input | 1 | Lookup hit |
| tlb_ppn | input | 32 | Physical page number of the hit |
| tlb_rd_en | input | 4 | Per-mode read enables |
| tlb_wr_en | input | 4 | Per-mode write enables |
| tlb_fonr | input | 1 | Entry fault-on-read |
| tlb_fonw | input | 1 | Entry fault-on-write |
| rsp_valid | output | 1 | Result valid |
| rsp_paddr | output | 64 | Physical address |
| rsp_uncached | output | 1 | Uncacheable access |
| rsp_fault | output | 3 | Fault code |
| rsp_status | output | 6 | Status word |
| rd_acc_cnt | output | 16 | Read table accesses |
| rd_hit_cnt | output | 16 | Read hits |
| rd_miss_cnt | output | 16 | Read misses |
| rd_acv_cnt | output | 16 | Read violations |
| wr_acc_cnt | output | 16 | Write table accesses |
| wr_hit_cnt | output | 16 | Write hits |
| wr_miss_cnt | output | 16 | Write misses |
| wr_acv_cnt | output | 16 | Write violations |
| tot_acc_cnt | output | 16 | Total accesses |
| tot_hit_cnt | output | 16 | Total hits |
| tot_miss_cnt | output | 16 | Total misses |
| tot_acv_cnt | output | 16 | Total violations |

## Verification
The classification is combinational and registered once, so a wrong priority or mode choice shows up in the fault code and status word on the cycle after the request. An error in the counter state shows only as a tally that drifts. The bench therefore keeps its own tally of every request category and compares all twelve counter outputs after the run. Priority is probed by requests that violate several rules at once, and only the highest-ranked rule should be reported.

// File: rtl/dtx_pkg.sv
// Shared types for the data translation fault classifier.
// Assumes a single request per cycle; codes are fixed by the block spec.
package dtx_pkg;
    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_ALIGN  = 3'd1,
        FLT_ACV    = 3'd2,
        FLT_PAGE   = 3'd3,
        FLT_PTMISS = 3'd4,
        FLT_NMISS  = 3'd5,
        FLT_MCHK   = 3'd6
    } fault_e;

    typedef enum logic [1:0] {
        MODE_KERNEL = 2'd0,
        MODE_EXEC   = 2'd1,
        MODE_SUPER  = 2'd2,
        MODE_USER   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_HIT  = 2'd1,
        EV_MISS = 2'd2,
        EV_ACV  = 2'd3
    } cnt_ev_e;

    localparam int ST_W     = 6;
    localparam int ST_WR    = 0;
    localparam int ST_ACV   = 1;
    localparam int ST_FONR  = 2;
    localparam int ST_FONW  = 3;
    localparam int ST_MISS  = 4;
    localparam int ST_BADVA = 5;
endpackage

// File: rtl/dtx_mode_sel.sv
// Effective-mode selector.
// Picks the privilege mode used for permission checks: the current mode
// normally, or (when the PC low bit is set) the alternate mode or kernel.
// Assumes all inputs are stable within the request cycle.
module dtx_mode_sel
    import dtx_pkg::*;
(
    input  logic  pc_lsb,
    input  logic  use_alt,
    input  mode_e cur_mode,
    input  mode_e alt_mode,
    output mode_e eff_mode
);
    // Select the mode that governs the enable-mask lookup.
    always_comb begin
        if (!pc_lsb)      eff_mode = cur_mode;
        else if (use_alt) eff_mode = alt_mode;
        else              eff_mode = MODE_KERNEL;
    end
endmodule

// File: rtl/dtx_check_chain.sv
// Prioritised check chain for one data access.
// Evaluates alignment, bypass, address form, direct-mapped window, lookup
// result and permissions in fixed order, then the physical range and the
// uncacheable rule. Purely combinational; assumes the lookaside response
// belongs to the address presented in the same cycle.
module dtx_check_chain
    import dtx_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int VA_IMPL_W = 48,
    parameter int PA_IMPL_W = 44,
    parameter int PG_SHIFT  = 13,
    parameter int PPN_W     = 32,
    parameter int SP_LO     = 41,
    parameter logic [6:0] SP_TAG = 7'h7E,
    parameter int UC_SPAN   = 8
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic [3:0]       size,
    input  logic             write,
    input  logic             phys,
    input  logic             ptacc,
    input  mode_e            cur_mode,
    input  mode_e            eff_mode,
    input  logic             tlb_hit,
    input  logic [PPN_W-1:0] tlb_ppn,
    input  logic [3:0]       tlb_rd_en,
    input  logic [3:0]       tlb_wr_en,
    input  logic             tlb_fonr,
    input  logic             tlb_fonw,
    output fault_e           fault,
    output logic [ST_W-1:0]  status,
    output logic [VA_W-1:0]  paddr,
    output logic             uncached,
    output cnt_ev_e          ev,
    output logic             tbl_acc
);
    localparam int SP_HI  = SP_LO + 6;
    localparam int HP_W   = PPN_W + PG_SHIFT;
    localparam int SX_BIT = PA_IMPL_W - 4;
    localparam int UC_BIT = PA_IMPL_W - 1;
    localparam logic [VA_W-1:0] IMPL_MASK = (VA_W'(1) << PA_IMPL_W) - VA_W'(1);
    localparam logic [VA_W-1:0] LOW_MASK  = (VA_W'(1) << SX_BIT) - VA_W'(1);
    localparam logic [VA_W-1:0] EXT_MASK  = IMPL_MASK & ~LOW_MASK;
    localparam logic [VA_W-1:0] UC_CLR    =
        ((VA_W'(1) << UC_SPAN) - VA_W'(1)) << (UC_BIT - UC_SPAN);

    logic [2:0]      size_mask;
    logic            misaligned;
    logic            canonical;
    logic            in_window;
    logic [VA_W-1:0] hit_pa;
    logic [VA_W-1:0] sp_raw;
    logic [VA_W-1:0] sp_pa;
    logic            range_chk;

    // Low-bit mask of the access size; unknown sizes act as one byte.
    always_comb begin
        case (size)
            4'd2:    size_mask = 3'b001;
            4'd4:    size_mask = 3'b011;
            4'd8:    size_mask = 3'b111;
            default: size_mask = 3'b000;
        endcase
    end

    // Address-shape predicates and candidate physical addresses.
    always_comb begin
        misaligned = |(vaddr[2:0] & size_mask);
        canonical  = (&vaddr[VA_W-1:VA_IMPL_W-1]) | ~(|vaddr[VA_W-1:VA_IMPL_W-1]);
        in_window  = (vaddr[SP_HI:SP_LO] == SP_TAG);
        hit_pa     = {{(VA_W-HP_W){1'b0}}, tlb_ppn, vaddr[PG_SHIFT-1:0]};
        sp_raw     = vaddr & IMPL_MASK;
        sp_pa      = sp_raw[SX_BIT] ? (sp_raw | EXT_MASK) : (sp_raw & LOW_MASK);
    end

    // Fixed-priority classification followed by the physical-address rules.
    always_comb begin
        fault     = FLT_NONE;
        status    = '0;
        paddr     = vaddr;
        uncached  = 1'b0;
        ev        = EV_NONE;
        tbl_acc   = 1'b0;
        range_chk = 1'b0;
        if (misaligned) begin
            fault         = FLT_ALIGN;
            status[ST_WR] = write;
        end else if (phys) begin
            ev        = EV_HIT;
            range_chk = 1'b1;
        end else if (!canonical) begin
            fault            = FLT_PAGE;
            status[ST_WR]    = write;
            status[ST_ACV]   = 1'b1;
            status[ST_BADVA] = 1'b1;
            ev               = EV_ACV;
        end else if (in_window) begin
            if (cur_mode != MODE_KERNEL) begin
                fault          = FLT_ACV;
                status[ST_WR]  = write;
                status[ST_ACV] = 1'b1;
                ev             = EV_ACV;
            end else begin
                paddr     = sp_pa;
                ev        = EV_HIT;
                range_chk = 1'b1;
            end
        end else begin
            tbl_acc = 1'b1;
            if (!tlb_hit) begin
                fault           = ptacc ? FLT_PTMISS : FLT_NMISS;
                status[ST_WR]   = write;
                status[ST_MISS] = 1'b1;
                ev              = EV_MISS;
            end else begin
                paddr = hit_pa;
                if (write) begin
                    if (!tlb_wr_en[eff_mode]) begin
                        fault           = FLT_PAGE;
                        status[ST_WR]   = 1'b1;
                        status[ST_ACV]  = 1'b1;
                        status[ST_FONW] = tlb_fonw;
                        ev              = EV_ACV;
                    end else if (tlb_fonw) begin
                        fault           = FLT_PAGE;
                        status[ST_WR]   = 1'b1;
                        status[ST_FONW] = 1'b1;
                        ev              = EV_ACV;
                    end else begin
                        ev        = EV_HIT;
                        range_chk = 1'b1;
                    end
                end else begin
                    if (!tlb_rd_en[eff_mode]) begin
                        fault           = FLT_ACV;
                        status[ST_ACV]  = 1'b1;
                        status[ST_FONR] = tlb_fonr;
                        ev              = EV_ACV;
                    end else if (tlb_fonr) begin
                        fault           = FLT_PAGE;
                        status[ST_FONR] = 1'b1;
                        ev              = EV_ACV;
                    end else begin
                        ev        = EV_HIT;
                        range_chk = 1'b1;
                    end
                end
            end
        end
        if (range_chk) begin
            if (|(paddr & ~IMPL_MASK)) begin
                fault = FLT_MCHK;
            end else if (paddr[UC_BIT]) begin
                uncached = 1'b1;
                paddr    = paddr & ~UC_CLR;
            end
        end
    end
endmodule

// File: rtl/dtx_event_counters.sv
// Read/write event counters.
// Keeps one counter per direction and per event kind (table access, hit,
// miss, violation) and forms the per-kind totals. Assumes at most one
// request per cycle; counters wrap at their width.
module dtx_event_counters
    import dtx_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int N_KIND = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fire,
    input  logic                          write,
    input  logic                          tbl_acc,
    input  cnt_ev_e                       ev,
    output logic [N_KIND-1:0][CNT_W-1:0]  rd_cnt,
    output logic [N_KIND-1:0][CNT_W-1:0]  wr_cnt,
    output logic [N_KIND-1:0][CNT_W-1:0]  tot_cnt
);
    for (genvar d = 0; d < 2; d++) begin : g_dir
        for (genvar k = 0; k < N_KIND; k++) begin : g_kind
            logic             bump;
            logic [CNT_W-1:0] cnt;
            // Kind 0 counts table accesses; kinds 1..3 match the event code.
            always_comb begin
                if (k == 0) bump = fire && (write == (d == 1)) && tbl_acc;
                else        bump = fire && (write == (d == 1)) && (ev == cnt_ev_e'(k));
            end
            // Advance the counter on its event.
            always_ff @(posedge clk) begin
                if (!rst_n)    cnt <= '0;
                else if (bump) cnt <= cnt + CNT_W'(1);
            end
            if (d == 0) begin : g_rd
                assign rd_cnt[k] = cnt;
            end else begin : g_wr
                assign wr_cnt[k] = cnt;
            end
        end
    end

    for (genvar k = 0; k < N_KIND; k++) begin : g_tot
        assign tot_cnt[k] = rd_cnt[k] + wr_cnt[k];

        // R10
        tot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tot_cnt[k] == $past(tot_cnt[k])) || (tot_cnt[k] == $past(tot_cnt[k]) + CNT_W'(1)));
    end
endmodule

// File: rtl/dtx_fault_classifier.sv
// Data translation fault classifier (top).
// Drives the lookaside query, classifies each request through the check
// chain, registers the result one cycle later and updates event counters.
// Assumes the lookaside answers combinationally in the request cycle.
module dtx_fault_classifier
    import dtx_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int VA_IMPL_W = 48,
    parameter int PA_IMPL_W = 44,
    parameter int PG_SHIFT  = 13,
    parameter int PPN_W     = 32,
    parameter int ASN_W     = 8,
    parameter int CNT_W     = 16,
    localparam int VPN_W    = VA_IMPL_W - PG_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [3:0]        req_size,
    input  logic              req_write,
    input  logic              req_phys,
    input  logic              req_alt,
    input  logic              req_ptacc,
    input  logic              pc_lsb,
    input  logic [1:0]        cur_mode,
    input  logic [1:0]        alt_mode,
    input  logic [ASN_W-1:0]  req_asn,
    output logic [VPN_W-1:0]  tlb_vpn,
    output logic [ASN_W-1:0]  tlb_asn,
    input  logic              tlb_hit,
    input  logic [PPN_W-1:0]  tlb_ppn,
    input  logic [3:0]        tlb_rd_en,
    input  logic [3:0]        tlb_wr_en,
    input  logic              tlb_fonr,
    input  logic              tlb_fonw,
    output logic              rsp_valid,
    output logic [VA_W-1:0]   rsp_paddr,
    output logic              rsp_uncached,
    output logic [2:0]        rsp_fault,
    output logic [ST_W-1:0]   rsp_status,
    output logic [CNT_W-1:0]  rd_acc_cnt,
    output logic [CNT_W-1:0]  rd_hit_cnt,
    output logic [CNT_W-1:0]  rd_miss_cnt,
    output logic [CNT_W-1:0]  rd_acv_cnt,
    output logic [CNT_W-1:0]  wr_acc_cnt,
    output logic [CNT_W-1:0]  wr_hit_cnt,
    output logic [CNT_W-1:0]  wr_miss_cnt,
    output logic [CNT_W-1:0]  wr_acv_cnt,
    output logic [CNT_W-1:0]  tot_acc_cnt,
    output logic [CNT_W-1:0]  tot_hit_cnt,
    output logic [CNT_W-1:0]  tot_miss_cnt,
    output logic [CNT_W-1:0]  tot_acv_cnt
);
    localparam int UC_BIT = PA_IMPL_W - 1;

    mode_e            eff_mode;
    fault_e           c_fault;
    logic [ST_W-1:0]  c_status;
    logic [VA_W-1:0]  c_paddr;
    logic             c_uc;
    cnt_ev_e          c_ev;
    logic             c_acc;
    logic [3:0][CNT_W-1:0] rd_cnt;
    logic [3:0][CNT_W-1:0] wr_cnt;
    logic [3:0][CNT_W-1:0] tot_cnt;

    assign tlb_vpn = req_vaddr[VA_IMPL_W-1:PG_SHIFT];
    assign tlb_asn = req_asn;

    dtx_mode_sel u_mode (
        .pc_lsb   (pc_lsb),
        .use_alt  (req_alt),
        .cur_mode (mode_e'(cur_mode)),
        .alt_mode (mode_e'(alt_mode)),
        .eff_mode (eff_mode)
    );

    dtx_check_chain #(
        .VA_W(VA_W), .VA_IMPL_W(VA_IMPL_W), .PA_IMPL_W(PA_IMPL_W),
        .PG_SHIFT(PG_SHIFT), .PPN_W(PPN_W)
    ) u_chain (
        .vaddr     (req_vaddr),
        .size      (req_size),
        .write     (req_write),
        .phys      (req_phys),
        .ptacc     (req_ptacc),
        .cur_mode  (mode_e'(cur_mode)),
        .eff_mode  (eff_mode),
        .tlb_hit   (tlb_hit),
        .tlb_ppn   (tlb_ppn),
        .tlb_rd_en (tlb_rd_en),
        .tlb_wr_en (tlb_wr_en),
        .tlb_fonr  (tlb_fonr),
        .tlb_fonw  (tlb_fonw),
        .fault     (c_fault),
        .status    (c_status),
        .paddr     (c_paddr),
        .uncached  (c_uc),
        .ev        (c_ev),
        .tbl_acc   (c_acc)
    );

    dtx_event_counters #(.CNT_W(CNT_W), .N_KIND(4)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (req_valid),
        .write   (req_write),
        .tbl_acc (c_acc),
        .ev      (c_ev),
        .rd_cnt  (rd_cnt),
        .wr_cnt  (wr_cnt),
        .tot_cnt (tot_cnt)
    );

    // Register the classification one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_paddr    <= '0;
            rsp_uncached <= 1'b0;
            rsp_fault    <= FLT_NONE;
            rsp_status   <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_paddr    <= c_paddr;
                rsp_uncached <= c_uc;
                rsp_fault    <= c_fault;
                rsp_status   <= c_status;
            end
        end
    end

    assign rd_acc_cnt   = rd_cnt[0];
    assign rd_hit_cnt   = rd_cnt[1];
    assign rd_miss_cnt  = rd_cnt[2];
    assign rd_acv_cnt   = rd_cnt[3];
    assign wr_acc_cnt   = wr_cnt[0];
    assign wr_hit_cnt   = wr_cnt[1];
    assign wr_miss_cnt  = wr_cnt[2];
    assign wr_acv_cnt   = wr_cnt[3];
    assign tot_acc_cnt  = tot_cnt[0];
    assign tot_hit_cnt  = tot_cnt[1];
    assign tot_miss_cnt = tot_cnt[2];
    assign tot_acv_cnt  = tot_cnt[3];

    // R12
    resp_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R12
    resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R12
    clean_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_fault == FLT_NONE) |-> (rsp_status == '0));

    // R9
    uc_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_uncached |-> (rsp_fault == FLT_NONE) && rsp_paddr[UC_BIT]);

    // R5
    miss_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && ((rsp_fault == FLT_PTMISS) || (rsp_fault == FLT_NMISS))
        |-> rsp_status[ST_MISS] && !rsp_status[ST_ACV]);

    // R1
    align_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_fault == FLT_ALIGN) |-> (rsp_status[ST_W-1:1] == '0));
endmodule

// File: tb/dtx_fault_classifier_bench.sv
module dtx_fault_classifier_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_vaddr = '0;
    logic [3:0]  req_size = 4'd1;
    logic        req_write = 1'b0, req_phys = 1'b0, req_alt = 1'b0, req_ptacc = 1'b0;
    logic        pc_lsb = 1'b0;
    logic [1:0]  cur_mode = 2'd0, alt_mode = 2'd0;
    logic [7:0]  req_asn = 8'h00;
    logic [34:0] tlb_vpn;
    logic [7:0]  tlb_asn;
    logic        t_hit = 1'b0;
    logic [31:0] t_ppn = '0;
    logic [3:0]  t_rd = 4'hF, t_wr = 4'hF;
    logic        t_fonr = 1'b0, t_fonw = 1'b0;
    logic        rsp_valid, rsp_uncached;
    logic [63:0] rsp_paddr;
    logic [2:0]  rsp_fault;
    logic [5:0]  rsp_status;
    logic [15:0] rd_acc_cnt, rd_hit_cnt, rd_miss_cnt, rd_acv_cnt;
    logic [15:0] wr_acc_cnt, wr_hit_cnt, wr_miss_cnt, wr_acv_cnt;
    logic [15:0] tot_acc_cnt, tot_hit_cnt, tot_miss_cnt, tot_acv_cnt;

    int tests = 0;
    int fails = 0;
    int e_cnt [2][4];

    always #5 clk = ~clk;

    dtx_fault_classifier u_dtx_fault_classifier (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_size(req_size), .req_write(req_write), .req_phys(req_phys),
        .req_alt(req_alt), .req_ptacc(req_ptacc), .pc_lsb(pc_lsb),
        .cur_mode(cur_mode), .alt_mode(alt_mode), .req_asn(req_asn),
        .tlb_vpn(tlb_vpn), .tlb_asn(tlb_asn), .tlb_hit(t_hit), .tlb_ppn(t_ppn),
        .tlb_rd_en(t_rd), .tlb_wr_en(t_wr), .tlb_fonr(t_fonr), .tlb_fonw(t_fonw),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_uncached(rsp_uncached),
        .rsp_fault(rsp_fault), .rsp_status(rsp_status),
        .rd_acc_cnt(rd_acc_cnt), .rd_hit_cnt(rd_hit_cnt), .rd_miss_cnt(rd_miss_cnt),
        .rd_acv_cnt(rd_acv_cnt), .wr_acc_cnt(wr_acc_cnt), .wr_hit_cnt(wr_hit_cnt),
        .wr_miss_cnt(wr_miss_cnt), .wr_acv_cnt(wr_acv_cnt), .tot_acc_cnt(tot_acc_cnt),
        .tot_hit_cnt(tot_hit_cnt), .tot_miss_cnt(tot_miss_cnt), .tot_acv_cnt(tot_acv_cnt)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One request: drive at negedge, sample the registered result one cycle later.
    // ev: 0 none, 1 hit, 2 miss, 3 violation; acc: counts as a table access.
    task automatic run(input string req, input logic [63:0] va, input logic [3:0] sz,
                       input logic wr, input logic ph, input logic alt, input logic pt,
                       input logic pcl, input logic [1:0] cm, input logic [1:0] am,
                       input logic [2:0] e_f, input logic [5:0] e_s,
                       input logic chk_pa, input logic [63:0] e_pa, input logic e_uc,
                       input int ev, input logic acc);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_size = sz; req_write = wr;
        req_phys = ph; req_alt = alt; req_ptacc = pt; pc_lsb = pcl;
        cur_mode = cm; alt_mode = am;
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " valid"}, 64'(rsp_valid), 64'd1);
        chk({req, " fault"}, 64'(rsp_fault), 64'(e_f));
        chk({req, " status"}, 64'(rsp_status), 64'(e_s));
        chk({req, " uncached"}, 64'(rsp_uncached), 64'(e_uc));
        if (chk_pa) chk({req, " paddr"}, rsp_paddr, e_pa);
        if (acc) e_cnt[wr][0]++;
        if (ev != 0) e_cnt[wr][ev]++;
    endtask

    task automatic t_reset();
        chk("R12 reset valid", 64'(rsp_valid), 64'd0);
        chk("R12 reset fault", 64'(rsp_fault), 64'd0);
        chk("R10 reset count", 64'(tot_acc_cnt), 64'd0);
    endtask

    task automatic t_align();
        // R1: misaligned and non-canonical together: alignment wins
        run("R1 store", 64'h8000_0000_0000_0002, 4'd4, 1, 0, 0, 0, 0, 0, 0, 3'd1, 6'h01, 0, 0, 0, 0, 0);
        run("R1 load", 64'h0000_0000_0000_0004, 4'd8, 0, 1, 0, 0, 0, 0, 0, 3'd1, 6'h00, 0, 0, 0, 0, 0);
        // R11: odd size acts as one byte
        run("R11 size3", 64'h0000_0000_0000_1001, 4'd3, 0, 1, 0, 0, 0, 0, 0, 3'd0, 6'h00, 1, 64'h1001, 0, 1, 0);
    endtask

    task automatic t_canon();
        run("R3 load", 64'h0000_8000_0000_0000, 4'd1, 0, 0, 0, 0, 0, 0, 0, 3'd3, 6'h22, 0, 0, 0, 3, 0);
        run("R3 store", 64'h0000_8000_0000_0000, 4'd1, 1, 0, 0, 0, 0, 0, 0, 3'd3, 6'h23, 0, 0, 0, 3, 0);
    endtask

    task automatic t_window();
        // R4: effective mode kernel but current user: still refused
        run("R4 user", 64'hFFFF_FC00_0000_1234, 4'd1, 0, 0, 0, 0, 1, 3, 0, 3'd2, 6'h02, 0, 0, 0, 3, 0);
        run("R4 user st", 64'hFFFF_FC00_0000_1234, 4'd1, 1, 0, 0, 0, 0, 3, 0, 3'd2, 6'h03, 0, 0, 0, 3, 0);
        run("R4 kernel", 64'hFFFF_FC00_0000_1234, 4'd1, 0, 0, 0, 0, 0, 0, 0, 3'd0, 6'h00, 1, 64'h1234, 0, 1, 0);
        // R9: bit 40 set extends into 43, then uncacheable clears 42:35
        run("R9 window uc", 64'hFFFF_FD00_0000_0040, 4'd1, 0, 0, 0, 0, 0, 0, 0, 3'd0, 6'h00, 1, 64'h800_0000_0040, 1, 1, 0);
    endtask

    task automatic t_miss();
        t_hit = 1'b0;
        req_asn = 8'h5A;
        run("R5 pt miss", 64'h0000_0000_0000_2000, 4'd1, 0, 0, 0, 1, 0, 0, 0, 3'd4, 6'h10, 0, 0, 0, 2, 1);
        run("R5 n miss st", 64'h0000_0000_0000_2000, 4'd1, 1, 0, 0, 0, 0, 0, 0, 3'd5, 6'h11, 0, 0, 0, 2, 1);
        @(negedge clk);
        req_vaddr = 64'h0000_1234_5678_A000;
        #1;
        chk("R5 lookup vpn", 64'(tlb_vpn), 64'h0_91A2_B3C5);
        chk("R5 lookup asn", 64'(tlb_asn), 64'h5A);
    endtask

    task automatic t_load_perm();
        t_hit = 1'b1; t_ppn = 32'h5; t_rd = 4'b0001; t_fonr = 1'b0;
        run("R7 user", 64'h2ABC, 4'd1, 0, 0, 0, 0, 0, 3, 0, 3'd2, 6'h02, 0, 0, 0, 3, 1);
        t_fonr = 1'b1;
        run("R7 user fonr", 64'h2ABC, 4'd1, 0, 0, 0, 0, 0, 3, 0, 3'd2, 6'h06, 0, 0, 0, 3, 1);
        t_rd = 4'hF;
        run("R7 fonr only", 64'h2ABC, 4'd1, 0, 0, 0, 0, 0, 3, 0, 3'd3, 6'h04, 0, 0, 0, 3, 1);
        t_fonr = 1'b0;
        run("R8 load hit", 64'h2ABC, 4'd1, 0, 0, 0, 0, 0, 3, 0, 3'd0, 6'h00, 1, 64'hAABC, 0, 1, 1);
    endtask

    task automatic t_eff_mode();
        t_hit = 1'b1; t_ppn = 32'h5; t_rd = 4'b0001; t_fonr = 1'b0;
        run("R2 pc kernel", 64'h2ABC, 4'd1, 0, 0, 0, 0, 1, 3, 3, 3'd0, 6'h00, 1, 64'hAABC, 0, 1, 1);
        run("R2 alt user", 64'h2ABC, 4'd1, 0, 0, 1, 0, 1, 0, 3, 3'd2, 6'h02, 0, 0, 0, 3, 1);
        run("R2 alt kernel", 64'h2ABC, 4'd1, 0, 0, 1, 0, 1, 3, 0, 3'd0, 6'h00, 0, 0, 0, 1, 1);
        run("R2 alt ignored", 64'h2ABC, 4'd1, 0, 0, 1, 0, 0, 3, 0, 3'd2, 6'h02, 0, 0, 0, 3, 1);
    endtask

    task automatic t_store_perm();
        t_hit = 1'b1; t_ppn = 32'h5; t_wr = 4'b0001; t_fonw = 1'b0;
        run("R6 user", 64'h2ABC, 4'd1, 1, 0, 0, 0, 0, 3, 0, 3'd3, 6'h03, 0, 0, 0, 3, 1);
        t_fonw = 1'b1;
        run("R6 user fonw", 64'h2ABC, 4'd1, 1, 0, 0, 0, 0, 3, 0, 3'd3, 6'h0B, 0, 0, 0, 3, 1);
        t_wr = 4'hF;
        run("R6 fonw only", 64'h2ABC, 4'd1, 1, 0, 0, 0, 0, 3, 0, 3'd3, 6'h09, 0, 0, 0, 3, 1);
        t_fonw = 1'b0;
        run("R6 store hit", 64'h2ABC, 4'd1, 1, 0, 0, 0, 0, 3, 0, 3'd0, 6'h00, 1, 64'hAABC, 0, 1, 1);
    endtask

    task automatic t_range();
        t_hit = 1'b1; t_rd = 4'hF; t_ppn = 32'h8000_0000;
        run("R8 hit mchk", 64'h0123, 4'd1, 0, 0, 0, 0, 0, 0, 0, 3'd6, 6'h00, 0, 0, 0, 1, 1);
        run("R8 phys mchk", 64'h0010_0000_0000_0000, 4'd1, 1, 1, 0, 0, 0, 0, 0, 3'd6, 6'h00, 0, 0, 0, 1, 0);
        run("R9 phys uc", 64'h0000_0FFF_FFFF_F000, 4'd1, 1, 1, 0, 0, 0, 0, 0, 3'd0, 6'h00, 1, 64'h807_FFFF_F000, 1, 1, 0);
    endtask

    task automatic t_counters();
        @(negedge clk);
        chk("R10 rd acc", 64'(rd_acc_cnt), 64'(e_cnt[0][0]));
        chk("R10 rd hit", 64'(rd_hit_cnt), 64'(e_cnt[0][1]));
        chk("R10 rd miss", 64'(rd_miss_cnt), 64'(e_cnt[0][2]));
        chk("R10 rd acv", 64'(rd_acv_cnt), 64'(e_cnt[0][3]));
        chk("R10 wr acc", 64'(wr_acc_cnt), 64'(e_cnt[1][0]));
        chk("R10 wr hit", 64'(wr_hit_cnt), 64'(e_cnt[1][1]));
        chk("R10 wr miss", 64'(wr_miss_cnt), 64'(e_cnt[1][2]));
        chk("R10 wr acv", 64'(wr_acv_cnt), 64'(e_cnt[1][3]));
        chk("R10 tot acc", 64'(tot_acc_cnt), 64'(e_cnt[0][0] + e_cnt[1][0]));
        chk("R10 tot hit", 64'(tot_hit_cnt), 64'(e_cnt[0][1] + e_cnt[1][1]));
        chk("R10 tot miss", 64'(tot_miss_cnt), 64'(e_cnt[0][2] + e_cnt[1][2]));
        chk("R10 tot acv", 64'(tot_acv_cnt), 64'(e_cnt[0][3] + e_cnt[1][3]));
        chk("R12 idle valid", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        for (int d = 0; d < 2; d++)
            for (int k = 0; k < 4; k++) e_cnt[d][k] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_align();
        t_canon();
        t_window();
        t_miss();
        t_load_perm();
        t_eff_mode();
        t_store_perm();
        t_range();
        t_counters();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule